// File: doc/BRIEF.md
# Four-Phase Completion-Detect Handshake Controller

This block is a clocked model of the interface stage that sits in front of a self-timed combinational unit. The environment raises a request; the unit reports its own activity on one or more busy lines, one per detector, each high while its sub-circuit is switching. The controller merges the busy lines into one output-valid signal, waits a guard interval after the request rises so that a busy pulse the detectors report late cannot be missed, and then drives an acknowledge under a four-phase return-to-zero protocol. When the request drops, the acknowledge drops with no guard at all.

The request and every busy line pass through two-flop synchronizers. The guard interval is a parameter counted in clock cycles and should be set just above the detector response time: any extra cycle is paid on every transaction. A sticky protocol-error flag records an environment that breaks the event order, and a latency counter reports, for each transaction, how long the request waited for its acknowledge.

The control path is a four-state machine. `ST_IDLE` waits for a synchronized rising edge of the request (transition IDLE to GUARD, which loads the guard counter). `ST_GUARD` counts the guard down. When the count is zero and the merged valid is high, it takes GUARD to ACK. A request that drops in this state takes GUARD to IDLE and raises the error flag. `ST_ACK` holds the acknowledge high until the synchronized request is low (ACK to IDLE). A fourth encoding, `ST_SPARE`, is unreachable and returns to IDLE.

Top module: `hs4_ctrl`

## Requirements
- R1: After reset `ack_out` is 0, `valid_out` is 1, `proto_err` is 0 and `lat_valid` is 0.
- R2: With every busy line low, `ack_out` rises exactly GUARD_CYC+3 clock edges after `req_in` rises: 2 edges of synchronizer, 1 edge to enter the guard, GUARD_CYC edges of guard.
- R3: A busy pulse that begins and ends inside the guard interval does not delay `ack_out` beyond GUARD_CYC+3 edges.
- R4: If a busy line is high from the request edge for B edges, with B > GUARD_CYC, `ack_out` rises exactly B+3 edges after `req_in` rises, and never while the merged valid, as last sampled, is low.
- R5: `valid_out` is the NOR of the synchronized busy lines. It is low whenever any single line, including the highest-index one, is high, and high only when all lines are low. It lags `busy_in` by two edges.
- R6: `ack_out` falls exactly 3 edges after `req_in` falls. There is no guard on this edge.
- R7: If the synchronized request falls while the machine is guarding, before any acknowledge, `proto_err` is set and no acknowledge is given for that request.
- R8: If the synchronized request rises in the cycle right after the acknowledge was still high, so that the environment cannot have seen the acknowledge fall, `proto_err` is set. The new request is still served.
- R9: `proto_err` stays set until reset, whatever later traffic occurs.
- R10: In the first cycle that `ack_out` is high, `lat_valid` pulses high for one cycle and `lat_cycles` holds the number of cycles spent guarding. That number is max(GUARD_CYC, B) for a busy window of B edges as in R4, and never less than GUARD_CYC.
- R11: `ack_out` rises only while the synchronized request is high, and falls only after the synchronized request was seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 1 | Request from the environment (asynchronous) |
| busy_in | input | N_DET | Busy lines, one per detector, high while its sub-circuit is active |
| ack_out | output | 1 | Acknowledge to the environment |
| valid_out | output | 1 | Merged, synchronized output-valid (NOR of busy lines) |
| proto_err | output | 1 | Sticky protocol-violation flag |
| lat_cycles | output | LAT_W | Guard cycles spent by the latest transaction |
| lat_valid | output | 1 | One-cycle strobe marking a new `lat_cycles` value |

## Verification
Two things can fall in one cycle: the guard counter reaching zero and the merged valid returning high. The long-busy scenario releases a busy line so that its synchronized fall lands on the same edge at which the counter is zero or later. The bench checks that the acknowledge waits one further edge, at B+3, and that the reported latency equals B. A second coincidence is a request that drops and rises again in the edge just after the acknowledge fell. The bench provokes it with a one-cycle low pulse on the request. It judges the result by a raised error flag and by a transaction that still completes normally.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_ACK   = 2'd2,
        ST_SPARE = 2'd3
    } hs4_state_e;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[b] <= 1'b0;
                    stage2[b] <= 1'b0;
                end else begin
                    stage1[b] <= d_in[b];
                    stage2[b] <= stage1[b];
                end
            end
        end
    endgenerate

    assign q_out = stage2;

endmodule

// File: rtl/hs4_guard.sv
module hs4_guard #(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int GCW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);
    localparam logic [GCW-1:0] LOAD_VAL = GCW'(GUARD_CYC - 1);

    logic [GCW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/hs4_latency.sv
module hs4_latency #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic             grant,
    output logic [LAT_W-1:0] lat_cycles,
    output logic             lat_valid
);

    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    logic [LAT_W-1:0] running;
    logic [LAT_W-1:0] running_inc;

    assign running_inc = (running == LAT_MAX) ? LAT_MAX : running + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running    <= '0;
            lat_cycles <= '0;
            lat_valid  <= 1'b0;
        end else begin
            lat_valid <= grant;
            if (grant) begin
                lat_cycles <= running_inc;
            end
            if (counting && !grant) begin
                running <= running_inc;
            end else begin
                running <= '0;
            end
        end
    end

endmodule

// File: rtl/hs4_ctrl.sv
module hs4_ctrl
    import hs4_pkg::*;
#(
    parameter int N_DET     = 2,
    parameter int GUARD_CYC = 4,
    parameter int LAT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic [N_DET-1:0] busy_in,
    output logic             ack_out,
    output logic             valid_out,
    output logic             proto_err,
    output logic [LAT_W-1:0] lat_cycles,
    output logic             lat_valid
);

    hs4_state_e state;
    hs4_state_e state_nx;

    logic             req_s;
    logic             req_s_d;
    logic             ack_d;
    logic [N_DET-1:0] busy_s;
    logic             req_rise;
    logic             guard_zero;
    logic             guard_load;
    logic             grant;
    logic             early_drop;
    logic             re_raise;

    hs4_sync #(.W(1)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (req_in),
        .q_out (req_s)
    );

    hs4_sync #(.W(N_DET)) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (busy_in),
        .q_out (busy_s)
    );

    assign valid_out = ~|busy_s;

    hs4_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (guard_load),
        .run     (state == ST_GUARD),
        .expired (guard_zero)
    );

    hs4_latency #(.LAT_W(LAT_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .counting   (state == ST_GUARD),
        .grant      (grant),
        .lat_cycles (lat_cycles),
        .lat_valid  (lat_valid)
    );

    assign req_rise = req_s && !req_s_d;

    always_comb begin
        state_nx   = state;
        guard_load = 1'b0;
        grant      = 1'b0;
        early_drop = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_rise) begin
                    state_nx   = ST_GUARD;
                    guard_load = 1'b1;
                end
            end
            ST_GUARD: begin
                if (!req_s) begin
                    state_nx   = ST_IDLE;
                    early_drop = 1'b1;
                end else if (guard_zero && valid_out) begin
                    state_nx = ST_ACK;
                    grant    = 1'b1;
                end
            end
            ST_ACK: begin
                if (!req_s) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SPARE: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign re_raise = req_rise && ack_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_s_d   <= 1'b0;
            ack_d     <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            state     <= state_nx;
            req_s_d   <= req_s;
            ack_d     <= ack_out;
            proto_err <= proto_err | early_drop | re_raise;
        end
    end

    always_comb begin
        ack_out = 1'b0;
        unique case (state)
            ST_IDLE:  ack_out = 1'b0;
            ST_GUARD: ack_out = 1'b0;
            ST_ACK:   ack_out = 1'b1;
            ST_SPARE: ack_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs4_ctrl_chk.sv
module hs4_ctrl_chk #(
    parameter int GUARD_CYC = 4,
    parameter int LAT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_s,
    input logic             ack_out,
    input logic             valid_out,
    input logic             proto_err,
    input logic [LAT_W-1:0] lat_cycles,
    input logic             lat_valid
);

    // R4
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> $past(valid_out));

    // R11
    ack_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> $past(req_s));

    // R11
    ack_fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> !$past(req_s));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);

    // R10
    lat_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> lat_valid);

    // R10
    lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> (lat_cycles >= LAT_W'(GUARD_CYC)));

    // R10
    lat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |=> !lat_valid);

endmodule

bind hs4_ctrl hs4_ctrl_chk #(
    .GUARD_CYC (GUARD_CYC),
    .LAT_W     (LAT_W)
) u_hs4_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .ack_out    (ack_out),
    .valid_out  (valid_out),
    .proto_err  (proto_err),
    .lat_cycles (lat_cycles),
    .lat_valid  (lat_valid)
);

// File: tb/test_hs4_ctrl.sv
module test_hs4_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_DET      = 2;
    localparam int GUARD_CYC  = 4;
    localparam int LAT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_in = 1'b0;
    logic [N_DET-1:0] busy_in = '0;
    logic             ack_out;
    logic             valid_out;
    logic             proto_err;
    logic [LAT_W-1:0] lat_cycles;
    logic             lat_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    hs4_ctrl #(.N_DET(N_DET), .GUARD_CYC(GUARD_CYC), .LAT_W(LAT_W)) i_hs4_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .busy_in    (busy_in),
        .ack_out    (ack_out),
        .valid_out  (valid_out),
        .proto_err  (proto_err),
        .lat_cycles (lat_cycles),
        .lat_valid  (lat_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input int actual, input int expected);
        total = total + 1;
        if (actual != expected) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset();
        req_in  = 1'b0;
        busy_in = '0;
        rst_n   = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic release_req();
        req_in = 1'b0;
        step(2);
        check("R6 ack still high 2 edges after req fall", int'(ack_out), 1);
        step(1);
        check("R6 ack low 3 edges after req fall", int'(ack_out), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 ack after reset", int'(ack_out), 0);
        check("R1 valid after reset", int'(valid_out), 1);
        check("R1 err after reset", int'(proto_err), 0);
        check("R1 lat_valid after reset", int'(lat_valid), 0);
    endtask

    task automatic t_plain();
        req_in = 1'b1;
        step(GUARD_CYC + 2);
        check("R2 ack low one edge before guard end", int'(ack_out), 0);
        step(1);
        check("R2 ack at GUARD_CYC+3", int'(ack_out), 1);
        check("R10 lat_valid strobe", int'(lat_valid), 1);
        check("R10 lat equals guard", int'(lat_cycles), GUARD_CYC);
        step(1);
        check("R10 lat_valid single cycle", int'(lat_valid), 0);
        release_req();
    endtask

    task automatic t_short_busy();
        req_in = 1'b1;
        step(1);
        busy_in[0] = 1'b1;
        step(1);
        busy_in[0] = 1'b0;
        step(GUARD_CYC);
        check("R3 short busy ack not early", int'(ack_out), 0);
        step(1);
        check("R3 short busy ack at guard end", int'(ack_out), 1);
        check("R3 short busy latency", int'(lat_cycles), GUARD_CYC);
        release_req();
    endtask

    task automatic t_long_busy(input int idx, input int blen);
        req_in = 1'b1;
        busy_in[idx] = 1'b1;
        step(2);
        check("R5 valid low with one busy line", int'(valid_out), 0);
        step(blen - 2);
        busy_in[idx] = 1'b0;
        step(2);
        check("R4 ack waits for valid", int'(ack_out), 0);
        check("R5 valid high when all lines low", int'(valid_out), 1);
        step(1);
        check("R4 ack at B+3", int'(ack_out), 1);
        check("R10 latency equals busy window", int'(lat_cycles), blen);
        release_req();
    endtask

    task automatic t_early_drop();
        do_reset();
        req_in = 1'b1;
        step(3);
        req_in = 1'b0;
        step(3);
        check("R7 err on drop during guard", int'(proto_err), 1);
        check("R7 no ack on dropped request", int'(ack_out), 0);
        step(6);
        check("R7 still no ack later", int'(ack_out), 0);
        check("R9 err stays set", int'(proto_err), 1);
        do_reset();
        check("R9 err cleared by reset", int'(proto_err), 0);
    endtask

    task automatic t_re_raise();
        do_reset();
        req_in = 1'b1;
        step(GUARD_CYC + 3);
        check("R8 first ack", int'(ack_out), 1);
        req_in = 1'b0;
        step(1);
        req_in = 1'b1;
        step(2);
        check("R8 err clear before rise is seen", int'(proto_err), 0);
        step(1);
        check("R8 err on re-raise before ack fell", int'(proto_err), 1);
        step(GUARD_CYC);
        check("R8 new request still served", int'(ack_out), 1);
        release_req();
        req_in = 1'b1;
        step(GUARD_CYC + 3);
        check("R9 err survives clean transaction", int'(proto_err), 1);
        release_req();
    endtask

    initial begin
        t_reset();
        t_plain();
        t_short_busy();
        t_long_busy(0, 9);
        t_long_busy(N_DET - 1, 12);
        t_plain();
        t_early_drop();
        t_re_raise();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule